// File: doc/BRIEF.md
# Buffered Synchronous Serial Channel

This block is a clocked serial port with a shift clock, a serial data output, a serial data input and a chip-select input. It holds an internal byte buffer and moves a whole block of bytes over the serial line by itself. The host does not handle each byte. The host fills the buffer through a simple write/read port, chooses a byte count and a mode, and pulses start. A busy flag stays high until the last bit has moved. The block then raises an interrupt request, which stays high until the host clears it.

The buffer can be used in two ways:
- **Shared mode.** The whole buffer is one area. Each received byte overwrites the location whose byte was just transmitted.
- **Split mode.** The lower half holds transmit data and the upper half collects received data.

The block can also act in two roles:
- **Master.** It generates its own shift clock, which idles high and has a period of twice `SCK_HALF` clocks.
- **Slave.** It follows an external shift clock. That clock counts only while chip select is low. While chip select is high, the data output is released.

Top module: `blkser_port`

## Requirements
- R1: After reset, `busy` and `irq` are 0, `sck_out` is 1 and `sck_oe` is 1 (master role).
- R2: In the master role the shift clock idles high. After an accepted start it stays high for `SCK_HALF` clocks and then toggles every `SCK_HALF` clocks, 16 times per byte. `busy` is 1 from the clock after start until the final rising edge, and the clock is high again from that edge on.
- R3: Bytes go out and come in MSB first. `sdo` changes only together with a falling edge of the shift clock, and `sdi` is sampled at the rising edge.
- R4: In shared mode, byte j is sent from buffer location j, for j = 0 to N-1. The byte received in its place is written to location j. Locations N and above are untouched.
- R5: In split mode, byte j is sent from location j and the byte received is written to location 64+j (DEPTH/2 + j). The lower half is not modified, and the count is limited to 64.
- R6: A start with count 0 is ignored. A start while busy is ignored. A count above 128 (DEPTH) is treated as 128.
- R7: `irq` rises in the same cycle that `busy` falls at the end of a transfer. It then stays 1 until a cycle with `irq_clr` high, and it is cleared by an accepted start. `busy` and `irq` are never 1 together.
- R8: In the slave role, the serial line moves only on edges of `sck_in` seen while `cs_n_in` is low. Data is sent and received MSB first, and the buffer is updated as in R4.
- R9: In the slave role, while `cs_n_in` is high, `sdo_oe` is 0 and edges on `sck_in` are ignored, so a transfer can pause and resume without losing bits.
- R10: Host writes to the buffer are ignored while `busy` is 1. Host reads return the addressed byte on the clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | 7 | Host buffer address |
| host_wdata | input | 8 | Host buffer write data |
| host_rdata | output | 8 | Buffer read data, one clock after the address |
| start | input | 1 | Start pulse |
| xfer_len | input | 8 | Byte count for the next transfer |
| split_sel | input | 1 | 1 selects split transmit/receive halves |
| slave_sel | input | 1 | 1 selects the external-clock slave role |
| irq_clr | input | 1 | Clears the interrupt request |
| sck_out | output | 1 | Shift clock driven in the master role |
| sck_oe | output | 1 | Shift clock output enable |
| sck_in | input | 1 | External shift clock in the slave role |
| cs_n_in | input | 1 | Chip select in the slave role, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer complete request |

## Verification
The master role is driven through three transfers:
- A short shared-mode transfer. This separates the pointer progression and the in-place overwrite from the timing.
- A split-mode transfer with a requested count above 64, carrying a host write aimed at a byte not yet sent. This shows whether the transfer is clamped, where received data lands, and whether host writes are blocked while busy.
- A full-buffer transfer with a count above 128 and a second start pulse in the middle of it. This exposes clamping at the far end and any restart by the second start.

The transmit and receive patterns use different byte values at every position, so a bit-order or addressing error shows up as a mismatch. A slave transfer driven by an external clock is paused with chip select high while extra clock edges arrive. Any bit lost or taken during that gap corrupts the read-back buffer.

// File: rtl/blkser_pkg.sv
// Shared types for the buffered serial channel.
package blkser_pkg;
    // One-cycle shift clock edge indications.
    typedef struct packed {
        logic fall;
        logic rise;
    } sck_evt_t;

    typedef logic [7:0] byte_t;
endpackage

// File: rtl/blkser_edge_gen.sv
// Shift clock edge source.
// Master role: divides clk into a shift clock that idles high and toggles
// every SCK_HALF cycles while run is 1.
// Slave role: synchronises sck_in, cs_n_in and sdi, and reports sck_in edges
// only while chip select is low.
// Assumes SCK_HALF >= 4 and external clock phases of at least 4 clocks.
module blkser_edge_gen
    import blkser_pkg::*;
#(
    parameter int SCK_HALF = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     slave,
    input  logic     sck_in,
    input  logic     cs_n_in,
    input  logic     sdi,
    output sck_evt_t evt,
    output logic     sck_int,
    output logic     sdi_smp
);
    localparam int CNT_W = $clog2(SCK_HALF + 1);

    logic [CNT_W-1:0] cnt;
    logic             sck_r;
    logic             tick;
    logic             s1, s2, s3;
    logic             c1, c2;
    logic             d1, d2;
    logic             cs_act;

    assign tick   = run && !slave && (cnt == CNT_W'(SCK_HALF - 1));
    assign cs_act = !c2;

    // Master divider: phase counter and internal shift clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            sck_r <= 1'b1;
        end else if (!run || slave) begin
            cnt   <= '0;
            sck_r <= 1'b1;
        end else if (tick) begin
            cnt   <= '0;
            sck_r <= ~sck_r;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // Slave input synchronisers for clock, select and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
            c1 <= 1'b1; c2 <= 1'b1;
            d1 <= 1'b0; d2 <= 1'b0;
        end else begin
            s1 <= sck_in; s2 <= s1; s3 <= s2;
            c1 <= cs_n_in; c2 <= c1;
            d1 <= sdi; d2 <= d1;
        end
    end

    // Edge selection for the active role.
    always_comb begin
        if (slave) begin
            evt.fall = run && cs_act && s3 && !s2;
            evt.rise = run && cs_act && !s3 && s2;
            sdi_smp  = d2;
        end else begin
            evt.fall = tick && sck_r;
            evt.rise = tick && !sck_r;
            sdi_smp  = sdi;
        end
    end

    assign sck_int = sck_r;

    p_half_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(SCK_HALF));

    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !slave) |=> sck_r);

    p_cs_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slave && c2) |-> (!evt.fall && !evt.rise));
endmodule

// File: rtl/blkser_buffer.sv
// Byte buffer shared by the host port and the shifter.
// The shifter reads asynchronously and writes at one address per cycle.
// The host reads with one cycle of latency.
// Assumes the caller never enables both writers in the same cycle.
module blkser_buffer
    import blkser_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_we,
    input  logic [$clog2(DEPTH)-1:0] host_addr,
    input  byte_t                    host_wdata,
    output byte_t                    host_rdata,
    input  logic [$clog2(DEPTH)-1:0] tx_addr,
    output byte_t                    tx_byte,
    input  logic                     rx_we,
    input  logic [$clog2(DEPTH)-1:0] rx_addr,
    input  byte_t                    rx_data
);
    byte_t mem [DEPTH];

    // Storage writes: the shifter first, otherwise the host.
    always_ff @(posedge clk) begin
        if (rx_we)
            mem[rx_addr] <= rx_data;
        else if (host_we)
            mem[host_addr] <= host_wdata;
    end

    // Registered host read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else
            host_rdata <= mem[host_addr];
    end

    assign tx_byte = mem[tx_addr];

    p_one_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_we && host_we));
endmodule

// File: rtl/blkser_shifter.sv
// Transfer sequencer and byte shifter.
// Accepts a start, clamps the count, and loads each byte on the falling edge
// that begins it. Samples one bit per rising edge and writes each completed
// byte back to the buffer. Raises irq when the count is exhausted.
// Assumes one edge event per cycle at most.
module blkser_shifter
    import blkser_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [$clog2(DEPTH):0]   xfer_len,
    input  logic                     split_sel,
    input  logic                     slave_sel,
    input  logic                     irq_clr,
    input  sck_evt_t                 evt,
    input  logic                     sdi_smp,
    input  byte_t                    tx_byte,
    output logic [$clog2(DEPTH)-1:0] tx_addr,
    output logic                     rx_we,
    output logic [$clog2(DEPTH)-1:0] rx_addr,
    output byte_t                    rx_data,
    output logic                     busy,
    output logic                     irq,
    output logic                     slave_q,
    output logic                     sdo_bit
);
    localparam int ADDR_W     = $clog2(DEPTH);
    localparam int LEN_W      = ADDR_W + 1;
    localparam int HALF_DEPTH = DEPTH / 2;

    logic [ADDR_W-1:0] ptr;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  lim;
    logic [LEN_W-1:0]  len_eff;
    logic [2:0]        bitcnt;
    logic              loaded;
    logic              split_q;
    logic              accept;
    byte_t             tx_sh;
    byte_t             rx_sh;

    assign lim     = split_sel ? LEN_W'(HALF_DEPTH) : LEN_W'(DEPTH);
    assign len_eff = (xfer_len > lim) ? lim : xfer_len;
    assign accept  = start && !busy && (xfer_len != '0);

    assign tx_addr = ptr;
    assign rx_addr = split_q ? (ptr | ADDR_W'(HALF_DEPTH)) : ptr;
    assign rx_data = {rx_sh[6:0], sdi_smp};
    assign rx_we   = busy && loaded && evt.rise && (bitcnt == 3'd7);
    assign sdo_bit = tx_sh[7];

    // Transfer control, byte loading and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            irq     <= 1'b0;
            split_q <= 1'b0;
            slave_q <= 1'b0;
            ptr     <= '0;
            remain  <= '0;
            bitcnt  <= 3'd7;
            loaded  <= 1'b0;
            tx_sh   <= 8'hFF;
            rx_sh   <= '0;
        end else begin
            if (irq_clr)
                irq <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                irq     <= 1'b0;
                split_q <= split_sel;
                slave_q <= slave_sel;
                ptr     <= '0;
                remain  <= len_eff;
                bitcnt  <= 3'd7;
                loaded  <= 1'b0;
            end else if (busy) begin
                if (evt.fall) begin
                    if (!loaded || bitcnt == 3'd7) begin
                        tx_sh  <= tx_byte;
                        bitcnt <= 3'd0;
                        loaded <= 1'b1;
                    end else begin
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                        bitcnt <= bitcnt + 3'd1;
                    end
                end
                if (evt.rise && loaded) begin
                    rx_sh <= rx_data;
                    if (bitcnt == 3'd7) begin
                        ptr    <= ptr + 1'b1;
                        remain <= remain - 1'b1;
                        if (remain == LEN_W'(1)) begin
                            busy   <= 1'b0;
                            irq    <= 1'b1;
                            loaded <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    p_busy_irq_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && irq));

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr && !start) |=> irq);

    p_split_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && split_q) |-> (ptr < ADDR_W'(HALF_DEPTH)));

    p_tx_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.fall |=> $stable(tx_sh));
endmodule

// File: rtl/blkser_port.sv
// Buffered synchronous serial channel, top level.
// Joins the edge source, the sequencer/shifter and the byte buffer. Blocks
// host writes during a transfer and forms the output enables.
// Assumes the host holds split_sel, slave_sel and xfer_len valid with start.
module blkser_port
    import blkser_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int SCK_HALF = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_we,
    input  logic [$clog2(DEPTH)-1:0] host_addr,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata,
    input  logic                     start,
    input  logic [$clog2(DEPTH):0]   xfer_len,
    input  logic                     split_sel,
    input  logic                     slave_sel,
    input  logic                     irq_clr,
    output logic                     sck_out,
    output logic                     sck_oe,
    input  logic                     sck_in,
    input  logic                     cs_n_in,
    input  logic                     sdi,
    output logic                     sdo,
    output logic                     sdo_oe,
    output logic                     busy,
    output logic                     irq
);
    localparam int ADDR_W = $clog2(DEPTH);

    sck_evt_t          evt;
    logic              sck_int;
    logic              sdi_smp;
    logic              slave_q;
    logic [ADDR_W-1:0] tx_addr;
    logic [ADDR_W-1:0] rx_addr;
    logic              rx_we;
    byte_t             rx_data;
    byte_t             tx_byte;
    logic              host_we_ok;

    assign host_we_ok = host_we && !busy;

    blkser_edge_gen #(.SCK_HALF(SCK_HALF)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .slave   (slave_q),
        .sck_in  (sck_in),
        .cs_n_in (cs_n_in),
        .sdi     (sdi),
        .evt     (evt),
        .sck_int (sck_int),
        .sdi_smp (sdi_smp)
    );

    blkser_shifter #(.DEPTH(DEPTH)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .xfer_len  (xfer_len),
        .split_sel (split_sel),
        .slave_sel (slave_sel),
        .irq_clr   (irq_clr),
        .evt       (evt),
        .sdi_smp   (sdi_smp),
        .tx_byte   (tx_byte),
        .tx_addr   (tx_addr),
        .rx_we     (rx_we),
        .rx_addr   (rx_addr),
        .rx_data   (rx_data),
        .busy      (busy),
        .irq       (irq),
        .slave_q   (slave_q),
        .sdo_bit   (sdo)
    );

    blkser_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we_ok),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tx_addr    (tx_addr),
        .tx_byte    (tx_byte),
        .rx_we      (rx_we),
        .rx_addr    (rx_addr),
        .rx_data    (rx_data)
    );

    assign sck_out = sck_int;
    assign sck_oe  = !slave_q;
    assign sdo_oe  = !slave_q || !cs_n_in;

    p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_q && !$stable(sdo)) |-> $fell(sck_out));

    p_host_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_we_ok);
endmodule

// File: tb/blkser_port_bench.sv
module blkser_port_bench;
    localparam int DEPTH = 128;
    localparam int H     = 4;
    localparam int SH    = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [6:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       start = 1'b0;
    logic [7:0] xfer_len = '0;
    logic       split_sel = 1'b0;
    logic       slave_sel = 1'b0;
    logic       irq_clr = 1'b0;
    logic       sck_out, sck_oe, sdo, sdo_oe, busy, irq;
    logic       sck_in = 1'b1;
    logic       cs_n_in = 1'b1;
    logic       sdi = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] txsnap [DEPTH];

    always #10 clk = ~clk;

    blkser_port #(.DEPTH(DEPTH), .SCK_HALF(H)) u_blkser_port (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .start(start),
        .xfer_len(xfer_len), .split_sel(split_sel), .slave_sel(slave_sel),
        .irq_clr(irq_clr), .sck_out(sck_out), .sck_oe(sck_oe), .sck_in(sck_in),
        .cs_n_in(cs_n_in), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .busy(busy), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] txpat(input int j, input int s);
        return 8'((j * 37 + s * 11 + 5) & 255);
    endfunction

    function automatic logic [7:0] rxpat(input int j, input int s);
        return 8'(((j * 91 + s * 29) & 255) ^ 8'h5A);
    endfunction

    task automatic fill(input int seed);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            host_we = 1'b1; host_addr = 7'(a); host_wdata = txpat(a, seed);
            model[a] = txpat(a, seed);
            txsnap[a] = txpat(a, seed);
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic readback(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            host_addr = 7'(a);
            @(negedge clk);
            chk(tag, int'(host_rdata), int'(model[a]));
        end
    endtask

    // Master transfer checked every cycle against a behavioural timing model.
    task automatic master_run(input int req, input bit split, input int seed,
                              input bit poke_wr, input bit poke_start);
        int lim = split ? DEPTH / 2 : DEPTH;
        int n = (req > lim) ? lim : req;
        int last = 16 * n * H;
        fill(seed);
        @(negedge clk);
        start = 1'b1; xfer_len = 8'(req); split_sel = split; slave_sel = 1'b0;
        for (int k = 0; k <= last; k++) begin
            int t;
            @(negedge clk);
            t = k / H;
            if (k == 0) start = 1'b0;
            chk("R2 busy", int'(busy), (k < last) ? 1 : 0);
            chk("R2 sck", int'(sck_out), (k >= last) ? 1 : (((t % 2) == 0) ? 1 : 0));
            if (t >= 1 && k < last) begin
                int i = (t - 1) / 2;
                chk("R3 sdo", int'(sdo), int'(txsnap[i / 8][7 - (i % 8)]));
                sdi = rxpat(i / 8, seed)[7 - (i % 8)];
            end
            if (poke_wr && k == 5) begin
                host_we = 1'b1; host_addr = 7'd10; host_wdata = ~txsnap[10];
            end
            if (poke_wr && k == 6) host_we = 1'b0;
            if (poke_start && k == 7) begin start = 1'b1; xfer_len = 8'd1; end
            if (poke_start && k == 8) start = 1'b0;
        end
        chk("R7 irq at end", int'(irq), 1);
        for (int j = 0; j < n; j++)
            model[split ? (DEPTH / 2 + j) : j] = rxpat(j, seed);
    endtask

    task automatic slave_bit(input logic [7:0] tb, input logic [7:0] rb, input int b);
        sck_in = 1'b0; sdi = rb[7 - b];
        tick(SH);
        chk("R8 slave sdo", int'(sdo), int'(tb[7 - b]));
        sck_in = 1'b1;
        tick(SH);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 sck_out", int'(sck_out), 1);
        chk("R1 sck_oe", int'(sck_oe), 1);

        // Shared mode, short transfer.
        master_run(3, 1'b0, 1, 1'b0, 1'b0);
        readback("R4 shared buffer");

        // irq held, then cleared.
        tick(5);
        chk("R7 irq held", int'(irq), 1);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
        chk("R7 irq cleared", int'(irq), 0);

        // Zero count is ignored.
        start = 1'b1; xfer_len = 8'd0; tick(1); start = 1'b0; tick(3);
        chk("R6 zero count", int'(busy), 0);

        // Split mode, clamped count, blocked host write.
        master_run(70, 1'b1, 2, 1'b1, 1'b0);
        readback("R5 R10 split buffer");
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0;

        // Full buffer, count above depth, second start ignored.
        master_run(200, 1'b0, 3, 1'b0, 1'b1);
        readback("R6 full buffer");

        // Slave role with a chip-select pause.
        fill(4);
        @(negedge clk);
        start = 1'b1; xfer_len = 8'd4; split_sel = 1'b0; slave_sel = 1'b1;
        tick(1); start = 1'b0; tick(2);
        chk("R8 sck_oe", int'(sck_oe), 0);
        chk("R9 sdo_oe idle", int'(sdo_oe), 0);
        cs_n_in = 1'b0; tick(SH);
        chk("R8 sdo_oe", int'(sdo_oe), 1);
        for (int j = 0; j < 4; j++) begin
            for (int b = 0; b < 8; b++) slave_bit(txsnap[j], rxpat(j, 4), b);
            if (j == 1) begin
                cs_n_in = 1'b1; tick(2);
                chk("R9 sdo_oe off", int'(sdo_oe), 0);
                for (int p = 0; p < 3; p++) begin
                    sck_in = 1'b0; sdi = ~sdi; tick(SH);
                    sck_in = 1'b1; tick(SH);
                end
                chk("R9 busy kept", int'(busy), 1);
                cs_n_in = 1'b0; tick(SH);
            end
        end
        tick(8);
        chk("R8 slave done", int'(busy), 0);
        chk("R7 slave irq", int'(irq), 1);
        cs_n_in = 1'b1;
        for (int j = 0; j < 4; j++) model[j] = rxpat(j, 4);
        readback("R8 slave buffer");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule